// File: doc/BRIEF.md
# Indexed Block Register Target for SMBus

This block is a serial bus target that holds a small configuration register file of eight bytes for a clock generator. A host reaches it with two transaction shapes. Both begin with a start index. A write then sends a byte count and that many data bytes, which land in consecutive registers. A read sends the start index, then a repeated start with the read bit. The target answers with a byte count taken from one of its own registers, then streams register contents from the start index onward for as long as the host acknowledges.

SCL and SDA arrive from the pins and are sampled by a much faster system clock. Both lines pass through a two-flop synchronizer and a three-sample agreement filter before start, stop and clock edges are decoded. SDA is driven only as an open-drain pull-low enable. The 7-bit target address and a spread-spectrum strap code are captured from strap inputs while reset is held. The register fields also appear as plain outputs, so that the rest of the generator can use them.

Top module: `smbus_cfg_target`

## Requirements
- R1: The target address is 7'b1101000 when the address strap captured during reset is 0, and 7'b1101010 when it is 1. For any other address the target does not pull SDA for the ACK, drives nothing, and ignores every later byte until the next start or stop.
- R2: On a write, the first byte after the address (write bit 0) sets the index and the second sets the byte count X. The next X data bytes are ACKed and stored at index, index+1, ..., index+X-1.
- R3: Data bytes of a write beyond the byte count, including any data byte when X is 0, get no ACK and change no register.
- R4: On a read (address byte with read bit 1 after an index was set), the target first sends the byte count and then sends bytes from the set index upward, incrementing after each byte. It keeps sending while the host ACKs and releases the bus after a NACK. Bits go out MSB first.
- R5: Index 7 holds the read byte count in bits 4:0, which are writable with reset value 8. Bits 7:5 read 0. The count byte sent on a read equals the index 7 value.
- R6: Index 0 (per-output enables) and index 2 (per-output slew, 1 = fast) are fully writable and reset to 8'hFF. Their values appear on out_en_o and slew_fast_o.
- R7: In index 1, bits 7:6 read back the spread strap code captured during reset and are read-only. Bit 5 is the software spread enable (reset 0). Bits 4:3 are the software spread code (reset 00). Bit 2 reads 1 and is read-only. Bits 1:0 are the amplitude code (reset 10).
- R8: In index 3, bits 7:6 are the reference slew code (reset 01), bit 5 is the wake-on-LAN enable (reset 0) and bit 4 is the reference enable (reset 1). Bits 3:0 read 4'hF and are read-only.
- R9: Index 4 reads 8'h00, index 5 reads 8'h01 and index 6 reads 8'h08. All three are read-only. Reads at indices above 7 return 8'h00, and writes there are ACKed within the count but change nothing.
- R10: A pulse on SCL or SDA shorter than three system-clock samples is ignored. It creates no bit, no start and no stop.
- R11: The SDA pull-low enable changes only while the filtered SCL is low, and is released after reset. The system clock must be at least about 40 times the SCL rate (for example 400 kHz SCL with a 125 MHz clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_strap_i | input | 1 | Address select strap |
| ss_strap_i | input | 2 | Spread strap code (00 off, 01 mid, 11 high) |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| out_en_o | output | 8 | Per-output enable bits (index 0) |
| slew_fast_o | output | 8 | Per-output fast slew bits (index 2) |
| ss_sw_en_o | output | 1 | Software spread enable (index 1 bit 5) |
| ss_sw_code_o | output | 2 | Software spread code (index 1 bits 4:3) |
| amp_code_o | output | 2 | Amplitude code (index 1 bits 1:0) |
| ref_slew_o | output | 2 | Reference slew code (index 3 bits 7:6) |
| wol_en_o | output | 1 | Wake-on-LAN enable (index 3 bit 5) |
| ref_en_o | output | 1 | Reference enable (index 3 bit 4) |

## Verification
The hardest situations to reach from the ports are a data byte arriving after the write count has run out, and sub-threshold glitches. A glitched SDA edge while SCL is high looks like a start or stop to any unfiltered decoder. The bench sends a count of two followed by three data bytes, and a count of zero with one data byte, then reads back the neighbouring register to prove the extra byte was refused. A bench-side bus model inserts two-cycle SCL pulses while SCL is low and two-cycle inverted SDA pulses while SCL is high in every bit of a write, and then checks the stored value. The strap-dependent address and readback bits are swept over all six strap combinations, each behind its own reset.

// File: rtl/smbus_cfg_target.sv
module smbus_cfg_target #(
  parameter int QUAL = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_strap_i,
  input  logic [1:0] ss_strap_i,
  output logic       sda_pull_o,
  output logic [7:0] out_en_o,
  output logic [7:0] slew_fast_o,
  output logic       ss_sw_en_o,
  output logic [1:0] ss_sw_code_o,
  output logic [1:0] amp_code_o,
  output logic [1:0] ref_slew_o,
  output logic       wol_en_o,
  output logic       ref_en_o
);

  localparam logic [6:0] ADDR_LO = 7'b1101000;
  localparam logic [6:0] ADDR_HI = 7'b1101010;

  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_INDEX, P_COUNT, P_WDATA, P_TXCNT, P_TXDATA} phase_t;

  logic [1:0]      scl_s, sda_s;
  logic [QUAL-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_q, sda_q;
  logic            start_det, stop_det, scl_rise, scl_fall;

  phase_t     phase;
  logic [3:0] bit_cnt;
  logic [7:0] sr, tx, idx, wcnt, rd_byte;
  logic       seen_rise, our_ack, host_ack, tx_phase, wr_hit;
  logic       strap_a;
  logic [1:0] strap_ss;
  logic [6:0] my_addr;

  logic [7:0] r_oe, r_slew;
  logic [4:0] r1w, r_bc;
  logic [3:0] r3w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[QUAL-2:0], scl_s[1]};
      sda_h <= {sda_h[QUAL-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign tx_phase  = (phase == P_TXCNT) || (phase == P_TXDATA);
  assign my_addr   = strap_a ? ADDR_HI : ADDR_LO;
  assign wr_hit    = scl_fall && seen_rise && (bit_cnt == 4'd7) && (phase == P_WDATA) && (wcnt != 8'd0);

  always_comb begin
    case (idx)
      8'd0:    rd_byte = r_oe;
      8'd1:    rd_byte = {strap_ss, r1w[4:2], 1'b1, r1w[1:0]};
      8'd2:    rd_byte = r_slew;
      8'd3:    rd_byte = {r3w, 4'hF};
      8'd5:    rd_byte = 8'h01;
      8'd6:    rd_byte = 8'h08;
      8'd7:    rd_byte = {3'b000, r_bc};
      default: rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_IDLE; bit_cnt <= '0; sr <= '0; tx <= '0; idx <= '0; wcnt <= '0;
      seen_rise <= 1'b0; our_ack <= 1'b0; host_ack <= 1'b0; sda_pull_o <= 1'b0;
      strap_a <= addr_strap_i;
      strap_ss <= ss_strap_i;
    end else if (start_det || stop_det) begin
      phase <= start_det ? P_ADDR : P_IDLE;
      bit_cnt <= '0; seen_rise <= 1'b0; our_ack <= 1'b0; sda_pull_o <= 1'b0;
    end else if (phase != P_IDLE) begin
      if (scl_rise) begin
        seen_rise <= 1'b1;
        if (bit_cnt != 4'd8) sr <= {sr[6:0], sda_f};
        else host_ack <= ~sda_f;
      end
      if (scl_fall && seen_rise) begin
        if (bit_cnt < 4'd7) begin
          bit_cnt <= bit_cnt + 4'd1;
          if (tx_phase) begin
            tx <= {tx[6:0], 1'b0};
            sda_pull_o <= ~tx[6];
          end
        end else if (bit_cnt == 4'd7) begin
          bit_cnt <= 4'd8;
          sda_pull_o <= 1'b0;
          case (phase)
            P_ADDR:
              if (sr[7:1] == my_addr) begin
                sda_pull_o <= 1'b1; our_ack <= 1'b1;
                if (sr[0]) begin
                  phase <= P_TXCNT;
                  tx <= {3'b000, r_bc};
                end else phase <= P_INDEX;
              end else phase <= P_IDLE;
            P_INDEX: begin idx <= sr; sda_pull_o <= 1'b1; our_ack <= 1'b1; phase <= P_COUNT; end
            P_COUNT: begin wcnt <= sr; sda_pull_o <= 1'b1; our_ack <= 1'b1; phase <= P_WDATA; end
            P_WDATA:
              if (wcnt != 8'd0) begin
                sda_pull_o <= 1'b1; our_ack <= 1'b1;
                wcnt <= wcnt - 8'd1;
                idx <= idx + 8'd1;
              end else phase <= P_IDLE;
            default: ;
          endcase
        end else begin
          bit_cnt <= '0;
          sda_pull_o <= 1'b0;
          our_ack <= 1'b0;
          if (our_ack) begin
            if (phase == P_TXCNT) sda_pull_o <= ~tx[7];
          end else if (tx_phase) begin
            if (host_ack) begin
              tx <= rd_byte;
              sda_pull_o <= ~rd_byte[7];
              idx <= idx + 8'd1;
              phase <= P_TXDATA;
            end else phase <= P_IDLE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_oe <= 8'hFF; r_slew <= 8'hFF; r1w <= 5'b00010; r3w <= 4'b0101; r_bc <= 5'd8;
    end else if (wr_hit) begin
      case (idx)
        8'd0: r_oe <= sr;
        8'd1: r1w <= {sr[5:3], sr[1:0]};
        8'd2: r_slew <= sr;
        8'd3: r3w <= sr[7:4];
        8'd7: r_bc <= sr[4:0];
        default: ;
      endcase
    end
  end

  assign out_en_o     = r_oe;
  assign slew_fast_o  = r_slew;
  assign ss_sw_en_o   = r1w[4];
  assign ss_sw_code_o = r1w[3:2];
  assign amp_code_o   = r1w[1:0];
  assign ref_slew_o   = r3w[3:2];
  assign wol_en_o     = r3w[1];
  assign ref_en_o     = r3w[0];

  // R11
  sda_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !$past(scl_f));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_IDLE) |-> !sda_pull_o);

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (idx == $past(idx) + 8'd1));

  // R6
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(r_oe) |-> ($past(wr_hit) && $past(idx) == 8'd0));

  // R8
  ref_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(r3w) |-> ($past(wr_hit) && $past(idx) == 8'd3));

endmodule

// File: tb/test_smbus_cfg_target.sv
module test_smbus_cfg_target;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic addr_strap = 1'b0;
  logic [1:0] ss_strap = 2'b00;
  logic sda_pull;
  logic [7:0] out_en, slew_fast;
  logic ss_sw_en, wol_en, ref_en;
  logic [1:0] ss_code, amp_code, ref_slew;
  wire  sda_line = host_sda & ~sda_pull;

  int total = 0, bad = 0, viol = 0;
  logic prev_pull = 1'b0;
  logic [7:0] mdl [8];
  logic [7:0] wbuf [16];
  logic [1:0] cur_ss;

  always #4 clk = ~clk;

  smbus_cfg_target i_smbus_cfg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .addr_strap_i(addr_strap), .ss_strap_i(ss_strap), .sda_pull_o(sda_pull),
    .out_en_o(out_en), .slew_fast_o(slew_fast), .ss_sw_en_o(ss_sw_en),
    .ss_sw_code_o(ss_code), .amp_code_o(amp_code), .ref_slew_o(ref_slew),
    .wol_en_o(wol_en), .ref_en_o(ref_en));

  always @(negedge clk) begin
    if (rst_n && (sda_pull !== prev_pull) && host_scl) viol++;
    prev_pull = sda_pull;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wmask(input int i);
    case (i)
      0, 2: return 8'hFF;
      1: return 8'h3B;
      3: return 8'hF0;
      7: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fixed(input int i);
    case (i)
      1: return {cur_ss, 6'b000100};
      3: return 8'h0F;
      5: return 8'h01;
      6: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rd_exp(input int i);
    if (i > 7) return 8'h00;
    return (mdl[i] & wmask(i)) | fixed(i);
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0, 2: return "R6";
      1: return "R7";
      3: return "R8";
      7: return "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [6:0] addr_of(input logic a);
    return a ? 7'b1101010 : 7'b1101000;
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    mdl[0] = 8'hFF; mdl[2] = 8'hFF; mdl[1] = 8'h02; mdl[3] = 8'h50; mdl[7] = 8'h08;
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_reset(input logic a, input logic [1:0] s);
    addr_strap = a; ss_strap = s; cur_ss = s;
    host_scl = 1'b1; host_sda = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mdl_reset();
  endtask

  task automatic chk_ports();
    logic [7:0] e1, e3;
    e1 = rd_exp(1); e3 = rd_exp(3);
    chk("R6 out_en_o", out_en, rd_exp(0));
    chk("R6 slew_fast_o", slew_fast, rd_exp(2));
    chk("R7 spread/amp ports", {3'b000, ss_sw_en, ss_code, amp_code}, {3'b000, e1[5], e1[4:3], e1[1:0]});
    chk("R8 reference ports", {4'h0, ref_slew, wol_en, ref_en}, {4'h0, e3[7:6], e3[5], e3[4]});
  endtask

  task automatic bus_start();
    host_sda = 1'b1; hq(); host_scl = 1'b1; hq(); host_sda = 1'b0; hq(); host_scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; hq(); host_scl = 1'b1; hq(); host_sda = 1'b1; hq();
  endtask

  task automatic put_byte(input logic [7:0] b, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; hq();
      if (glitch) begin
        host_scl = 1'b1; repeat (2) @(negedge clk); host_scl = 1'b0; hq();
      end
      host_scl = 1'b1; hq();
      if (glitch) begin
        host_sda = ~b[i]; repeat (2) @(negedge clk); host_sda = b[i];
      end
      hq(); host_scl = 1'b0; hq();
    end
    host_sda = 1'b1; hq(); host_scl = 1'b1; hq();
    ack = ~sda_line;
    hq(); host_scl = 1'b0; hq();
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      hq(); host_scl = 1'b1; hq();
      b = {b[6:0], sda_line};
      hq(); host_scl = 1'b0; hq();
    end
    host_sda = give_ack ? 1'b0 : 1'b1; hq(); host_scl = 1'b1; hq(); hq(); host_scl = 1'b0; hq();
    host_sda = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input int cnt, input int nsend,
                          input bit exp_ack, input bit glitch);
    logic ack;
    bus_start();
    put_byte({a, 1'b0}, 1'b0, ack);
    chk("R1 address ack", {7'd0, ack}, {7'd0, exp_ack});
    put_byte(8'(n), 1'b0, ack);
    chk(exp_ack ? "R2 index ack" : "R1 ignored index", {7'd0, ack}, {7'd0, exp_ack});
    put_byte(8'(cnt), 1'b0, ack);
    chk(exp_ack ? "R2 count ack" : "R1 ignored count", {7'd0, ack}, {7'd0, exp_ack});
    for (int k = 0; k < nsend; k++) begin
      bit want;
      want = exp_ack && (k < cnt);
      put_byte(wbuf[k], glitch, ack);
      chk(!exp_ack ? "R1 ignored data" : (want ? "R2 data ack" : "R3 excess data nack"),
          {7'd0, ack}, {7'd0, want});
      if (want && (n + k) < 8) mdl[n + k] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input int nget);
    logic ack;
    logic [7:0] b;
    bus_start();
    put_byte({a, 1'b0}, 1'b0, ack);
    chk("R4 read address ack", {7'd0, ack}, 8'd1);
    put_byte(8'(n), 1'b0, ack);
    chk("R4 read index ack", {7'd0, ack}, 8'd1);
    bus_start();
    put_byte({a, 1'b1}, 1'b0, ack);
    chk("R4 read direction ack", {7'd0, ack}, 8'd1);
    get_byte(1'b1, b);
    chk("R5 count byte", b, rd_exp(7));
    for (int k = 0; k < nget; k++) begin
      get_byte(k < nget - 1, b);
      chk(tag_of(n + k), b, rd_exp(n + k));
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 2; a++) begin
      for (int s = 0; s < 3; s++) begin
        do_reset(a[0], (s == 0) ? 2'b00 : (s == 1) ? 2'b01 : 2'b11);
        chk("R11 released after reset", {7'd0, sda_pull}, 8'd0);
        chk_ports();
        do_read(addr_of(a[0]), 0, 10);
        wbuf[0] = 8'h00; wbuf[1] = 8'h00;
        do_write(addr_of(~a[0]), 0, 2, 2, 1'b0, 1'b0);
        chk_ports();
      end
    end

    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 8; k++)
        wbuf[k] = (p == 0) ? 8'((k * 8'h5B) ^ 8'hA6) : (p == 1) ? 8'hFF : 8'h00;
      do_write(addr_of(1'b1), 0, 8, 8, 1'b1, 1'b0);
      chk_ports();
      do_read(addr_of(1'b1), 0, 10);
    end

    wbuf[0] = 8'h81; wbuf[1] = 8'h7E; wbuf[2] = 8'hFF;
    do_write(addr_of(1'b1), 1, 2, 3, 1'b1, 1'b0);
    do_read(addr_of(1'b1), 1, 3);
    chk_ports();

    wbuf[0] = 8'hFF;
    do_write(addr_of(1'b1), 3, 0, 1, 1'b1, 1'b0);
    do_read(addr_of(1'b1), 3, 1);

    wbuf[0] = 8'hAA; wbuf[1] = 8'hE3; wbuf[2] = 8'h55; wbuf[3] = 8'h55;
    do_write(addr_of(1'b1), 6, 4, 4, 1'b1, 1'b0);
    do_read(addr_of(1'b1), 5, 5);

    wbuf[0] = 8'h3C;
    do_write(addr_of(1'b1), 2, 1, 1, 1'b1, 1'b1);
    do_read(addr_of(1'b1), 2, 1);
    chk("R10 glitched write stored", slew_fast, 8'h3C);

    chk("R11 pull changes with SCL high", 8'(viol), 8'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule